// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-interrupt state for 64 interrupt sources and exposes that state through a 32-bit register read/write bus. Each source has three state bits: enable, pending and active. Each state has one register view that sets bits and another that clears them. Each source also has three configuration fields: a priority (only its upper four bits are stored), an 8-bit processor-target mask and a trigger mode. In edge mode a rising input latches pending. In level mode pending follows the input line.

Downstream prioritisation logic reads two things from the block. The first is a per-source forwarding vector: a source is forwarded when it is enabled and pending and the single global enable is on. The second is the 4-bit priority of every source. An acknowledge strobe that carries a source number marks that source active. It also clears the source's latched edge pending. Bus reads return data one cycle after the request. Unused, unaligned or out-of-range offsets read as zero and ignore writes.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset every enable, pending and active bit is 0, every priority, target and mode field is 0 (level), the global enable is 0, `rdata` is 0 and `fwd_req` is all zero.
- R2: Bit 0 of the word at offset 0x000 is the global enable and reads back in bit 0. While it is 0, `fwd_req` is all zero whatever the per-source state.
- R3: Source n's enable is bit n%32 of word n/32. Writing 1 to a bit at 0x100+4*(n/32) sets that enable, and writing 1 at 0x180+4*(n/32) clears it. Writing 0 bits changes nothing. Reading either offset returns the current enables.
- R4: Source n's mode is bit 2*(n%16)+1 of the word at 0xC00+4*(n/16). 1 (field value 0x2) selects edge and 0 selects level. Field bit 0 is not stored and reads 0. In edge mode, a rising input, or a 1 written at 0x200+4*(n/32), sets pending. Pending then stays set until a 1 is written at 0x280+4*(n/32) or the source is acknowledged. Both pending offsets read the pending bits.
- R5: In level mode, pending equals the input as sampled at the previous clock edge. Set-pending and clear-pending writes have no effect on it.
- R6: Active bits use the same per-word layout at 0x300 (set) and 0x380 (clear). An acknowledge (`ack_valid` with `ack_id`=n) sets active[n] and clears the latched pending of an edge-mode source n.
- R7: Source n's priority is byte n%4, at bits 8*(n%4)+7 to 8*(n%4), of the word at 0x400+4*(n/4). Only the upper four bits of the byte are stored, and the lower four read 0. Bits 4n+3 to 4n of `fwd_prio` carry the stored nibble, where 0 is the most urgent.
- R8: Source n's target mask is byte n%4 of the word at 0x800+4*(n/4). All 8 bits are stored and read back.
- R9: `fwd_req[n]` is 1 exactly when the global enable, enable[n] and pending[n] are all 1. It tracks the registered state with no added delay.
- R10: A read of any other offset returns 0, and a write to it has no effect. This covers words that would cover sources 64 and above and offsets whose low two bits are not 00.
- R11: `rdata` is loaded on the clock edge that samples `rd_en`, so it is valid the next cycle. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_in | input | 64 | Interrupt input lines, synchronous to clk |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 6 | Number of the acknowledged source |
| fwd_req | output | 64 | Per-source forward request |
| fwd_prio | output | 256 | Per-source 4-bit priority, packed |

## Verification
The hardest situation to reach is an edge-mode source whose input has already fallen but whose pending bit must stay latched. The bench must then tell the clearing paths apart (bus clear, acknowledge) and the setting paths apart (edge, bus set). To get there, the stimulus first switches a source to edge mode with a field value whose bit 0 is also set. It then pulses the line and drops it again, and only afterwards checks that pending has survived. Clear and set writes and an acknowledge follow. A level-mode source is then driven under the same pending writes to show that they are ignored. Out-of-range words next to valid ones are written with all ones, and the valid neighbours are read back to show that no write aliases onto them.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CTL,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_AC_SET,
    RG_AC_CLR,
    RG_PRIO,
    RG_TARG,
    RG_CFG
  } region_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/irq_bitvec.sv
module irq_bitvec #(
  parameter int NBIT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [4:0]      idx,
  input  logic [31:0]     wdata,
  input  logic [NBIT-1:0] hw_set,
  output logic [NBIT-1:0] bits,
  output logic [31:0]     rword
);

  localparam int NW = NBIT / 32;

  logic [NBIT-1:0] q, d, bus_set, bus_clr, set_all;
  logic            upd;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign bus_set[w*32 +: 32] = (set_we && idx == 5'(w)) ? wdata : 32'h0;
    assign bus_clr[w*32 +: 32] = (clr_we && idx == 5'(w)) ? wdata : 32'h0;
  end

  assign set_all = bus_set | hw_set;

  always_comb begin
    d   = (q & ~bus_clr) | set_all;
    upd = set_we | clr_we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= d;
    end
  end

  always_comb begin
    rword = 32'h0;
    for (int w = 0; w < NW; w++) begin
      if (idx == 5'(w)) rword = q[w*32 +: 32];
    end
  end

  assign bits = q;

  // No state bit rises without a set source in the cycle before
  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q)) & ~$past(set_all)) == '0);

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NBIT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBIT-1:0] irq_in,
  input  logic [NBIT-1:0] edge_mode,
  input  logic [NBIT-1:0] ack_clr,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [4:0]      idx,
  input  logic [31:0]     wdata,
  output logic [NBIT-1:0] pend,
  output logic [31:0]     rword
);

  localparam int NW = NBIT / 32;

  logic [NBIT-1:0] q, d, irq_q, rise, bus_set, bus_clr, edge_d;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign bus_set[w*32 +: 32] = (set_we && idx == 5'(w)) ? wdata : 32'h0;
    assign bus_clr[w*32 +: 32] = (clr_we && idx == 5'(w)) ? wdata : 32'h0;
  end

  assign rise = irq_in & ~irq_q;

  always_comb begin
    edge_d = (q & ~(bus_clr | ack_clr)) | bus_set | rise;
    d      = (edge_mode & edge_d) | (~edge_mode & irq_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      irq_q <= '0;
    end else begin
      q     <= d;
      irq_q <= irq_in;
    end
  end

  always_comb begin
    rword = 32'h0;
    for (int w = 0; w < NW; w++) begin
      if (idx == 5'(w)) rword = q[w*32 +: 32];
    end
  end

  assign pend = q;

  assert_edge_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(rise & edge_mode)) == $past(rise & edge_mode)));

  assert_level_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(irq_in)) & ~$past(edge_mode)) == '0));

endmodule

// File: rtl/irq_field_bank.sv
module irq_field_bank #(
  parameter int NFIELD = 64,
  parameter int FW     = 8,
  parameter int SW     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [7:0]         idx,
  input  logic [31:0]        wdata,
  output logic [NFIELD*SW-1:0] fields,
  output logic [31:0]        rword
);

  localparam int PW    = 32 / FW;
  localparam int NWORD = NFIELD / PW;

  logic [NFIELD*SW-1:0] q, d;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam int W = i / PW;
    localparam int F = i % PW;
    assign d[i*SW +: SW] = (we && idx == 8'(W)) ? wdata[F*FW+FW-SW +: SW]
                                                : q[i*SW +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

  always_comb begin
    rword = 32'h0;
    for (int w = 0; w < NWORD; w++) begin
      if (idx == 8'(w)) begin
        for (int f = 0; f < PW; f++) begin
          rword[f*FW+FW-SW +: SW] = q[(w*PW+f)*SW +: SW];
        end
      end
    end
  end

  assign fields = q;

endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter  int NUM_IRQ   = 64,
  parameter  int PRIO_BITS = 4,
  localparam int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NUM_IRQ-1:0]          irq_in,
  input  logic                        ack_valid,
  input  logic [ID_W-1:0]             ack_id,
  output logic [NUM_IRQ-1:0]          fwd_req,
  output logic [NUM_IRQ*PRIO_BITS-1:0] fwd_prio
);

  localparam int NW_BIT  = NUM_IRQ / 32;
  localparam int NW_BYTE = NUM_IRQ / 4;
  localparam int NW_CFG  = NUM_IRQ / 16;

  logic srst_n;

  irq_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(srst_n)
  );

  // Address decode
  region_e     region;
  logic [4:0]  bidx;
  logic [7:0]  fidx;

  assign bidx = addr[6:2];
  assign fidx = addr[9:2];

  always_comb begin
    region = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      unique case (addr[11:10])
        2'b00: begin
          if (addr[9:2] == 8'd0) begin
            region = RG_CTL;
          end else if (int'(bidx) < NW_BIT) begin
            case (addr[9:7])
              3'd2: region = RG_EN_SET;
              3'd3: region = RG_EN_CLR;
              3'd4: region = RG_PD_SET;
              3'd5: region = RG_PD_CLR;
              3'd6: region = RG_AC_SET;
              3'd7: region = RG_AC_CLR;
              default: region = RG_NONE;
            endcase
          end
        end
        2'b01: if (int'(fidx) < NW_BYTE) region = RG_PRIO;
        2'b10: if (int'(fidx) < NW_BYTE) region = RG_TARG;
        default: if (int'(fidx) < NW_CFG) region = RG_CFG;
      endcase
    end
  end

  // Global enable
  logic ctl_q, ctl_d, ctl_we;

  assign ctl_we = wr_en && (region == RG_CTL);
  assign ctl_d  = ctl_we ? wdata[0] : ctl_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= 1'b0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  // Acknowledge decode
  logic [NUM_IRQ-1:0] ack_vec;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ack
    assign ack_vec[i] = ack_valid && (ack_id == ID_W'(i));
  end

  // State banks
  logic [NUM_IRQ-1:0] en_bits, pd_bits, ac_bits;
  logic [31:0]        en_rword, pd_rword, ac_rword;

  irq_bitvec #(.NBIT(NUM_IRQ)) u_enable (
    .clk   (clk),
    .rst_n (srst_n),
    .set_we(wr_en && region == RG_EN_SET),
    .clr_we(wr_en && region == RG_EN_CLR),
    .idx   (bidx),
    .wdata (wdata),
    .hw_set('0),
    .bits  (en_bits),
    .rword (en_rword)
  );

  irq_bitvec #(.NBIT(NUM_IRQ)) u_active (
    .clk   (clk),
    .rst_n (srst_n),
    .set_we(wr_en && region == RG_AC_SET),
    .clr_we(wr_en && region == RG_AC_CLR),
    .idx   (bidx),
    .wdata (wdata),
    .hw_set(ack_vec),
    .bits  (ac_bits),
    .rword (ac_rword)
  );

  logic [NUM_IRQ-1:0] edge_mode;

  irq_pend #(.NBIT(NUM_IRQ)) u_pend (
    .clk      (clk),
    .rst_n    (srst_n),
    .irq_in   (irq_in),
    .edge_mode(edge_mode),
    .ack_clr  (ack_vec),
    .set_we   (wr_en && region == RG_PD_SET),
    .clr_we   (wr_en && region == RG_PD_CLR),
    .idx      (bidx),
    .wdata    (wdata),
    .pend     (pd_bits),
    .rword    (pd_rword)
  );

  logic [NUM_IRQ*PRIO_BITS-1:0] pr_fields;
  logic [NUM_IRQ*8-1:0]         tg_unused_fields;
  logic [31:0]                  pr_rword, tg_rword, cf_rword;

  irq_field_bank #(.NFIELD(NUM_IRQ), .FW(8), .SW(PRIO_BITS)) u_prio (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (wr_en && region == RG_PRIO),
    .idx   (fidx),
    .wdata (wdata),
    .fields(pr_fields),
    .rword (pr_rword)
  );

  irq_field_bank #(.NFIELD(NUM_IRQ), .FW(8), .SW(8)) u_target (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (wr_en && region == RG_TARG),
    .idx   (fidx),
    .wdata (wdata),
    .fields(tg_unused_fields),
    .rword (tg_rword)
  );

  irq_field_bank #(.NFIELD(NUM_IRQ), .FW(2), .SW(1)) u_cfg (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (wr_en && region == RG_CFG),
    .idx   (fidx),
    .wdata (wdata),
    .fields(edge_mode),
    .rword (cf_rword)
  );

  // Read path
  logic [31:0] rd_word, rdata_q, rdata_d;

  always_comb begin
    case (region)
      RG_CTL:               rd_word = {31'h0, ctl_q};
      RG_EN_SET, RG_EN_CLR: rd_word = en_rword;
      RG_PD_SET, RG_PD_CLR: rd_word = pd_rword;
      RG_AC_SET, RG_AC_CLR: rd_word = ac_rword;
      RG_PRIO:              rd_word = pr_rword;
      RG_TARG:              rd_word = tg_rword;
      RG_CFG:               rd_word = cf_rword;
      default:              rd_word = 32'h0;
    endcase
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= 32'h0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign fwd_req  = {NUM_IRQ{ctl_q}} & en_bits & pd_bits;
  assign fwd_prio = pr_fields;

  assert_ack_sets_active_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ack_valid |=> ac_bits[$past(ack_id)]);

  assert_prio_low_zero_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && region == RG_PRIO) |=> ((rdata & 32'h0F0F_0F0F) == 32'h0));

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && region == RG_NONE) |=> (rdata == 32'h0));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/irq_dist_bank_test.sv
module irq_dist_bank_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [63:0]  irq_in = '0;
  logic         ack_valid = 1'b0;
  logic [5:0]   ack_id = '0;
  logic [63:0]  fwd_req;
  logic [255:0] fwd_prio;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] addr_q[$];

  irq_dist_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack_valid(ack_valid),
    .ack_id(ack_id), .fwd_req(fwd_req), .fwd_prio(fwd_prio)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compare each returned read word with the scoreboard head
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data %h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        logic [11:0] a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = addr_q.pop_front();
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s read %h: actual %h expected %h", t, a, rdata, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t); addr_q.push_back(a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
    @(negedge clk);
  endtask

  task automatic ack(input int n);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = 6'(n);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic chk(input string t, input logic [255:0] act, input logic [255:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 fwd_req", 256'(fwd_req), 256'h0);
    chk("R1 rdata", 256'(rdata), 256'h0);
    chk("R1 fwd_prio", fwd_prio, 256'h0);
    rd(12'h000, 32'h0, "R1 ctl");
    rd(12'h100, 32'h0, "R1 enable");
    rd(12'h400, 32'h0, "R1 prio");

    // R2 global enable readback
    wr(12'h000, 32'h1);
    rd(12'h000, 32'h1, "R2 ctl");

    // R3 set/clear enable
    wr(12'h100, 32'h0000_0011);
    wr(12'h104, 32'h0800_0000);
    wr(12'h180, 32'h0000_0001);
    wr(12'h100, 32'h0);
    rd(12'h180, 32'h0000_0010, "R3 enable word0");
    rd(12'h104, 32'h0800_0000, "R3 enable word1");

    // R4 edge mode on source 59
    wr(12'hC0C, 32'h00C0_0000);
    rd(12'hC0C, 32'h0080_0000, "R4 mode field");
    line(59, 1'b1);
    chk("R4 edge sets", 256'(fwd_req[59]), 256'h1);
    line(59, 1'b0);
    chk("R4 edge held", 256'(fwd_req[59]), 256'h1);
    rd(12'h284, 32'h0800_0000, "R4 pending view");
    wr(12'h284, 32'h0800_0000);
    chk("R4 clear write", 256'(fwd_req[59]), 256'h0);
    wr(12'h204, 32'h0800_0000);
    chk("R4 set write", 256'(fwd_req[59]), 256'h1);

    // R6 acknowledge and active views
    ack(59);
    chk("R6 ack clears pending", 256'(fwd_req[59]), 256'h0);
    rd(12'h304, 32'h0800_0000, "R6 ack sets active");
    wr(12'h384, 32'h0800_0000);
    rd(12'h304, 32'h0, "R6 clear active");
    wr(12'h304, 32'h0800_0000);
    rd(12'h384, 32'h0800_0000, "R6 set active");

    // R5 level mode on source 4
    line(4, 1'b1);
    chk("R5 level follows high", 256'(fwd_req[4]), 256'h1);
    wr(12'h280, 32'h0000_0010);
    rd(12'h200, 32'h0000_0010, "R5 clear ignored");
    line(4, 1'b0);
    chk("R5 level follows low", 256'(fwd_req[4]), 256'h0);
    wr(12'h200, 32'h0000_0010);
    chk("R5 set ignored", 256'(fwd_req[4]), 256'h0);

    // R9 pending but disabled source 0
    line(0, 1'b1);
    chk("R9 disabled not forwarded", 256'(fwd_req[0]), 256'h0);
    rd(12'h200, 32'h0000_0001, "R9 pending without enable");
    line(0, 1'b0);

    // R2 global gating
    line(4, 1'b1);
    wr(12'h000, 32'h0);
    chk("R2 global off", 256'(fwd_req), 256'h0);
    rd(12'h000, 32'h0, "R2 ctl off");
    wr(12'h000, 32'h1);
    chk("R2 global on", 256'(fwd_req), 256'h10);

    // R7 priority
    wr(12'h404, 32'hABCD_EF12);
    rd(12'h404, 32'hA0C0_E010, "R7 prio word");
    chk("R7 prio source6", 256'(fwd_prio[27:24]), 256'hC);
    chk("R7 prio source4", 256'(fwd_prio[19:16]), 256'h1);

    // R8 target
    wr(12'h83C, 32'h8421_0F03);
    rd(12'h83C, 32'h8421_0F03, "R8 target word");

    // R10 unmapped offsets
    rd(12'h108, 32'h0, "R10 enable beyond range");
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0000_0010, "R10 no alias word0");
    rd(12'h104, 32'h0800_0000, "R10 no alias word1");
    wr(12'h440, 32'hFFFF_FFFF);
    rd(12'h440, 32'h0, "R10 prio beyond range");
    rd(12'h400, 32'h0, "R10 prio word0 untouched");
    rd(12'hC10, 32'h0, "R10 cfg beyond range");
    rd(12'h004, 32'h0, "R10 gap offset");
    rd(12'hF00, 32'h0, "R10 high offset");
    wr(12'h001, 32'h0);
    chk("R10 unaligned write ignored", 256'(fwd_req[4]), 256'h1);

    // R11 read data holds
    rd(12'h404, 32'hA0C0_E010, "R11 read");
    wr(12'h000, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", 256'(rdata), 256'hA0C0_E010);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule